// File: doc/BRIEF.md
# Write-to-Set Command and Status Register

This block is one 32-bit word of a USB host controller's register file. It holds the command bits that software uses to ask the controller for work. There is one bit for a controller reset, one that marks the control list as filled, one that marks the bulk list as filled, and one that asks for a change of ownership. Software reaches the word over a plain register bus with an address, write data, a write enable and combinational read data. A write can only turn bits on. A one in the write data sets the matching bit, and a zero leaves it as it was. Several agents can therefore issue separate commands without reading the word first, and no command overwrites another.

Hardware clears a command bit through a per-bit clear input once it has acted on that command. The current command bits are also driven out to the list processor. The word also holds a 2-bit count of frames whose periodic list did not complete before end of frame. Each one-cycle overrun pulse from the list processor advances the count, and on the same edge the block raises a one-cycle flag that the interrupt status logic latches.

Top module: `cmd_status_reg`

## Requirements
- R1: After reset, the read data at offset 08h is all zeros, the overrun flag is low and the command outputs are zero.
- R2: A write to offset 08h sets command bit i (bit 0 reset, bit 1 control filled, bit 2 bulk filled, bit 3 ownership request) for each i whose write-data bit is 1. Bits written as 0 keep their value.
- R3: Read data at offset 08h shows the command bits in bits 3:0 and the count in bits 17:16. Every other bit reads 0, even after a write of all ones.
- R4: A write to any other address changes nothing, and read data at any other address is zero.
- R5: Each overrun pulse raises the count by one on the next edge, and the count wraps from 3 to 0.
- R6: The overrun flag is high for exactly the one cycle after each overrun pulse, on the same edge as the count step, and is low otherwise.
- R7: A hardware clear of bit i clears that bit on the next edge. For bits 1 to 3, the clear wins over a software set in the same cycle.
- R8: For the reset bit (bit 0), a software set in the same cycle as its hardware clear wins, and the bit ends up set.
- R9: Software writes never change the count, including writes of ones to bits 17:16.
- R10: The command outputs always equal bits 3:0 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register bus byte address |
| regWrData | input | DATA_W | Register bus write data |
| regWrEn | input | 1 | Register bus write strobe |
| regRdData | output | DATA_W | Read data, combinational on regAddr |
| hwClr | input | 4 | Per-bit hardware clear of the command bits |
| ovrPulse | input | 1 | Scheduling overrun pulse from the list processor |
| ovrFlag | output | 1 | One-cycle overrun flag toward interrupt status |
| cmdOut | output | 4 | Current command bits |

## Verification
Two pairs of events can land in the same cycle. A software write can arrive in the same cycle as a hardware clear of the same bits. An overrun pulse can arrive in the same cycle as a write of ones to the count field. The bench provokes both pairs on purpose. It drives a write of all ones together with a full clear mask, and it expects only the reset bit to survive. It also drives a pulse together with a write aimed at the count, and it expects the count to advance by exactly one. A model built from the requirements predicts each outcome, and a scoreboard compares it one cycle later.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
  localparam int CMD_BITS = 4;   // reset, control filled, bulk filled, ownership
  localparam int RST_IDX  = 0;   // software set of this bit beats a clear
  localparam int CNT_W    = 2;
  localparam int CNT_POS  = 16;  // count field position in the word

  typedef struct packed {
    logic [CMD_BITS-1:0] setMask;  // resolved set strobes
    logic [CMD_BITS-1:0] clrMask;  // resolved clear strobes
    logic                cntInc;   // advance overrun count
  } strobe_t;
endpackage

// File: rtl/cmd_status_ctrl.sv
module cmd_status_ctrl
  import cmd_status_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h08
) (
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regWrEn,
  input  logic [CMD_BITS-1:0] hwClr,
  input  logic                ovrPulse,
  output logic                addrHit,
  output strobe_t             strobes
);
  logic                wrHit;
  logic [CMD_BITS-1:0] rawSet;
  logic                unusedWrBits;

  assign addrHit      = (regAddr == REG_OFFSET);
  assign wrHit        = regWrEn && addrHit;
  assign rawSet       = wrHit ? regWrData[CMD_BITS-1:0] : '0;
  assign unusedWrBits = ^regWrData[DATA_W-1:CMD_BITS];

  // Priority per bit: the clear wins, except on the reset bit.
  for (genvar i = 0; i < CMD_BITS; i++) begin : g_prio
    if (i == RST_IDX) begin : g_rst
      assign strobes.setMask[i] = rawSet[i];
      assign strobes.clrMask[i] = hwClr[i] && !rawSet[i];
    end else begin : g_cmd
      assign strobes.setMask[i] = rawSet[i] && !hwClr[i];
      assign strobes.clrMask[i] = hwClr[i];
    end
  end

  assign strobes.cntInc = ovrPulse;
endmodule

// File: rtl/cmd_status_dp.sv
module cmd_status_dp
  import cmd_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic                addrHit,
  output logic [DATA_W-1:0]   rdWord,
  output logic [CMD_BITS-1:0] cmdBits,
  output logic                ovrFlag
);
  logic [CNT_W-1:0] ovrCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdBits  <= '0;
      ovrCount <= '0;
      ovrFlag  <= 1'b0;
    end else begin
      cmdBits  <= (cmdBits & ~strobes.clrMask) | strobes.setMask;
      ovrCount <= ovrCount + CNT_W'(strobes.cntInc);  // wraps naturally
      ovrFlag  <= strobes.cntInc;
    end
  end

  always_comb begin
    rdWord = '0;
    if (addrHit) begin
      rdWord[CMD_BITS-1:0]          = cmdBits;
      rdWord[CNT_POS+:CNT_W]        = ovrCount;
    end
  end

  // Count steps by one per pulse (R5) and holds otherwise (R9).
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntInc |=> ovrCount == CNT_W'($past(ovrCount) + 1'b1));
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cntInc |=> $stable(ovrCount));
  assert_flag_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntInc |=> ovrFlag);
  assert_flag_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.cntInc |=> !ovrFlag);

  for (genvar i = 0; i < CMD_BITS; i++) begin : g_chk
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
      (cmdBits[i] && !strobes.clrMask[i]) |=> cmdBits[i]);
    if (i == RST_IDX) begin : g_rst
      assert_reset_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        strobes.setMask[i] |=> cmdBits[i]);
    end else begin : g_cmd
      assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
        strobes.clrMask[i] |=> !cmdBits[i]);
    end
  end
endmodule

// File: rtl/cmd_status_reg.sv
module cmd_status_reg
  import cmd_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h08
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regWrEn,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [CMD_BITS-1:0] hwClr,
  input  logic                ovrPulse,
  output logic                ovrFlag,
  output logic [CMD_BITS-1:0] cmdOut
);
  strobe_t strobes;
  logic    addrHit;

  cmd_status_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)) ctrl_i (
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .hwClr(hwClr), .ovrPulse(ovrPulse), .addrHit(addrHit), .strobes(strobes)
  );

  cmd_status_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addrHit(addrHit),
    .rdWord(regRdData), .cmdBits(cmdOut), .ovrFlag(ovrFlag)
  );

  // Reserved bits never read as one (R3).
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData & ~(DATA_W'({CNT_W{1'b1}}) << CNT_POS) & ~DATA_W'({CMD_BITS{1'b1}})) == '0);
endmodule

// File: tb/cmd_status_reg_tb.sv
module cmd_status_reg_tb_top;
  localparam logic [7:0] OFF = 8'h08;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = OFF;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regRdData;
  logic [3:0]  hwClr = '0;
  logic        ovrPulse = 1'b0;
  logic        ovrFlag;
  logic [3:0]  cmdOut;

  always #5 clk = ~clk;

  cmd_status_reg dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .hwClr(hwClr),
    .ovrPulse(ovrPulse), .ovrFlag(ovrFlag), .cmdOut(cmdOut)
  );

  typedef struct {
    string       req;
    logic [31:0] rd;
    logic        flag;
    logic [3:0]  cmd;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic [3:0] mBits = '0;
  logic [1:0] mCnt = '0;

  function automatic logic [31:0] word(input logic [7:0] a);
    return (a == OFF) ? {14'b0, mCnt, 12'b0, mBits} : 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] aRd, input logic [31:0] eRd,
                       input logic aF, input logic eF, input logic [3:0] aC, input logic [3:0] eC);
    checks++;
    if (aRd !== eRd || aF !== eF || aC !== eC) begin
      errors++;
      $display("FAIL %s: rd=%h flag=%b cmd=%h expected rd=%h flag=%b cmd=%h",
               req, aRd, aF, aC, eRd, eF, eC);
    end
  endtask

  // Driver: drives one cycle, then pushes the state the model predicts after the edge.
  task automatic step(input string req, input logic [7:0] a, input logic we,
                      input logic [31:0] d, input logic [3:0] clr, input logic p);
    item_t it;
    logic hit;
    @(negedge clk);
    regAddr = a; regWrEn = we; regWrData = d; hwClr = clr; ovrPulse = p;
    hit = we && (a == OFF);
    for (int i = 0; i < 4; i++) begin
      if (i == 0) mBits[i] = (hit && d[i]) ? 1'b1 : (clr[i] ? 1'b0 : mBits[i]);
      else        mBits[i] = clr[i] ? 1'b0 : ((hit && d[i]) ? 1'b1 : mBits[i]);
    end
    mCnt = mCnt + 2'(p);
    it.req = req; it.rd = word(a); it.flag = p; it.cmd = mBits;
    expQ.push_back(it);
  endtask

  // Monitor: compares one cycle's result shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        check(it.req, regRdData, it.rd, ovrFlag, it.flag, cmdOut, it.cmd);
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog: rd=%h flag=%b expected completion", regRdData, ovrFlag);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", regRdData, 32'h0, ovrFlag, 1'b0, cmdOut, 4'h0);
    @(negedge clk);
    rstN = 1'b1;
    step("R1", OFF, 1'b0, 32'h0, 4'h0, 1'b0);
    // R2 separate commands accumulate
    step("R2", OFF, 1'b1, 32'h2, 4'h0, 1'b0);
    step("R2", OFF, 1'b1, 32'h4, 4'h0, 1'b0);
    step("R2", OFF, 1'b1, 32'h0, 4'h0, 1'b0);
    step("R10", OFF, 1'b1, 32'h8, 4'h0, 1'b0);
    // R3 and R9: all ones, reserved and count stay zero
    step("R3", OFF, 1'b1, 32'hFFFF_FFFF, 4'h0, 1'b0);
    // R7 clears every bit without a set
    step("R7", OFF, 1'b0, 32'h0, 4'hF, 1'b0);
    // R4 stray write and read elsewhere
    step("R4", 8'h0C, 1'b1, 32'hFFFF_FFFF, 4'h0, 1'b0);
    step("R4", OFF, 1'b0, 32'h0, 4'h0, 1'b0);
    // R5 and R6: five pulses wrap the count
    for (int k = 0; k < 5; k++) step("R5", OFF, 1'b0, 32'h0, 4'h0, 1'b1);
    step("R6", OFF, 1'b0, 32'h0, 4'h0, 1'b0);
    step("R6", OFF, 1'b0, 32'h0, 4'h0, 1'b1);
    step("R6", OFF, 1'b0, 32'h0, 4'h0, 1'b0);
    // R7 and R8: set and clear in the same cycle
    step("R8", OFF, 1'b1, 32'hF, 4'hF, 1'b0);
    step("R7", OFF, 1'b1, 32'h6, 4'h0, 1'b0);
    step("R7", OFF, 1'b1, 32'h8, 4'h2, 1'b0);
    step("R7", OFF, 1'b0, 32'h0, 4'h5, 1'b0);
    // R9 pulse together with a write aimed at the count
    step("R9", OFF, 1'b1, 32'h0003_0000, 4'h0, 1'b1);
    step("R9", OFF, 1'b1, 32'h0003_0000, 4'h0, 1'b0);
    step("R10", OFF, 1'b0, 32'h0, 4'h0, 1'b0);
    @(negedge clk);
    regWrEn = 1'b0; hwClr = '0; ovrPulse = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule